// File: doc/BRIEF.md
# Push-Button Interrupt Conditioner

This block sits between a double-throw push button and the interrupt request line of a CPU. Each of the switch's two contacts is brought in on its own pin and passed through a two-flop synchronizer. The synchronized pair drives a set/reset latch that removes contact bounce. While the moving blade is between contacts, or if both contacts read closed, the latch holds its last value.

The debounced level is then presented to the CPU in one of two ways. In level mode, the active-low request simply mirrors the button: low while the button is pressed. In edge mode, each press sets a sticky request flag. That flag keeps the request low until the CPU pulses an acknowledge strobe, normally from its handler. A button held down therefore raises exactly one interrupt.

The mode is level after reset. Software may change it once, and only during a short window of clock cycles after reset. Any write outside that window, or any write after the first accepted one, is discarded.

Top module: `irqc_top`

## Requirements
- R1: Each contact input passes through two synchronizer flops and then the debounce latch. A contact change driven before clock edge N shows on `irq_n` in level mode after edge N+2, and not after edge N+1.
- R2: With `contact_press`=1 and `contact_release`=0, the debounced button reads pressed. With `contact_press`=0 and `contact_release`=1, it reads released.
- R3: With both contact inputs at 0, or both at 1, the debounced state keeps its previous value.
- R4: In level mode, `irq_n` is 0 exactly while the debounced button is pressed. `irq_ack` has no effect on `irq_n` in this mode.
- R5: In edge mode, each released-to-pressed transition of the debounced button drives `irq_n` to 0. `irq_n` stays 0, through release, until an acknowledge arrives.
- R6: In edge mode, a pulse on `irq_ack` returns `irq_n` to 1. A button still held after the acknowledge raises no further request until it is released and pressed again.
- R7: If a new press edge and `irq_ack` fall on the same clock edge, the press wins and `irq_n` stays 0.
- R8: While `rst` is high and after it is released, the block is in level mode, with the button released and `irq_n` at 1.
- R9: A write (`mode_wr`=1, `mode_edge`: 1 = edge, 0 = level) is accepted only on cycles 0 to 63 counted from the first clock edge with `rst` low. Only the first accepted write takes effect. Later writes, and writes on cycle 64 or after, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| contact_press | input | 1 | Contact closed when the button is down (latch set side) |
| contact_release | input | 1 | Contact closed when the button is up (latch reset side) |
| irq_ack | input | 1 | CPU acknowledge strobe that clears the edge request |
| mode_wr | input | 1 | Mode write strobe |
| mode_edge | input | 1 | Mode value written: 1 selects edge, 0 selects level |
| irq_n | output | 1 | Interrupt request to the CPU, active low |

## Verification
The assertions take for granted that `rst` is held high across the first clock edge, so that every register has a defined value before any property is evaluated. They also assume each contact changes at most once per clock, since the properties on the latch compare one sampled contact pair with the next latch state.

The stimulus keeps within these limits. Every input is driven on the falling clock edge. Each random contact pattern is held for four cycles, which is longer than the three-register path. Acknowledge pulses are issued only after the contacts have settled, except in the one directed case that lines an acknowledge up with the press edge on purpose.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic {
        MODE_LEVEL = 1'b0,
        MODE_EDGE  = 1'b1
    } irq_mode_e;

    typedef struct packed {
        logic set_c;   // press-side contact
        logic clr_c;   // release-side contact
    } contact_pair_t;

    // Latch state: 1 = released, 0 = pressed.
    // 10 -> pressed, 01 -> released; 00 and 11 keep the old state.
    function automatic logic sr_step(input contact_pair_t c, input logic q);
        logic nq;
        unique case ({c.set_c, c.clr_c})
            2'b10:   nq = 1'b0;
            2'b01:   nq = 1'b1;
            default: nq = q;
        endcase
        return nq;
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[i] <= '0;
            else     stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/irqc_debounce.sv
module irqc_debounce
    import irqc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  contact_pair_t contacts,
    output logic          released,
    output logic          press_evt
);
    logic q_next;

    always_comb q_next = sr_step(contacts, released);

    // Fires on the edge where the latch goes from released to pressed.
    assign press_evt = released & ~q_next;

    always_ff @(posedge clk) begin
        if (rst) released <= 1'b1;
        else     released <= q_next;
    end

    // R2
    sr_press_chk: assert property (@(posedge clk) disable iff (rst)
        (contacts.set_c && !contacts.clr_c) |=> !released);
    // R2
    sr_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!contacts.set_c && contacts.clr_c) |=> released);
    // R3
    sr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (contacts.set_c == contacts.clr_c) |=> $stable(released));

endmodule

// File: rtl/irqc_mode_cfg.sv
module irqc_mode_cfg
    import irqc_pkg::*;
#(
    parameter int WINDOW = 64
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  logic      wr_edge,
    output irq_mode_e mode
);
    localparam int CW = $clog2(WINDOW + 1);
    localparam logic [CW-1:0] LIMIT = CW'(WINDOW);

    logic [CW-1:0] age;
    logic          locked;
    logic          win_open;
    logic          accept;

    assign win_open = (age < LIMIT);
    assign accept   = wr & win_open & ~locked;

    always_ff @(posedge clk) begin
        if (rst) begin
            age    <= '0;
            locked <= 1'b0;
            mode   <= MODE_LEVEL;
        end else begin
            if (win_open) age <= age + 1'b1;
            if (accept) begin
                locked <= 1'b1;
                mode   <= wr_edge ? MODE_EDGE : MODE_LEVEL;
            end
        end
    end

    // R8
    reset_level_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mode == MODE_LEVEL));
    // R9
    window_shut_chk: assert property (@(posedge clk) disable iff (rst)
        !win_open |=> $stable(mode));
    // R9
    write_once_chk: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(mode));
    // R9
    window_stays_shut_chk: assert property (@(posedge clk) disable iff (rst)
        !win_open |=> !win_open);

endmodule

// File: rtl/irqc_edge_latch.sv
module irqc_edge_latch (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic set_evt,
    input  logic ack,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst || !enable) flag <= 1'b0;
        else if (set_evt)   flag <= 1'b1;   // new press beats acknowledge
        else if (ack)       flag <= 1'b0;
    end

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && set_evt) |=> flag);
    // R6
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && ack && !set_evt) |=> !flag);
    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && flag && !ack) |=> flag);
    // R4
    level_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !flag);

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CFG_WINDOW  = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic contact_press,
    input  logic contact_release,
    input  logic irq_ack,
    input  logic mode_wr,
    input  logic mode_edge,
    output logic irq_n
);
    contact_pair_t raw_c;
    contact_pair_t sync_c;
    logic          released;
    logic          press_evt;
    logic          edge_flag;
    irq_mode_e     mode;

    assign raw_c.set_c = contact_press;
    assign raw_c.clr_c = contact_release;

    irqc_sync #(.WIDTH($bits(contact_pair_t)), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_c),
        .q   (sync_c)
    );

    irqc_debounce u_deb (
        .clk       (clk),
        .rst       (rst),
        .contacts  (sync_c),
        .released  (released),
        .press_evt (press_evt)
    );

    irqc_mode_cfg #(.WINDOW(CFG_WINDOW)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr      (mode_wr),
        .wr_edge (mode_edge),
        .mode    (mode)
    );

    irqc_edge_latch u_edge (
        .clk     (clk),
        .rst     (rst),
        .enable  (mode == MODE_EDGE),
        .set_evt (press_evt),
        .ack     (irq_ack),
        .flag    (edge_flag)
    );

    assign irq_n = (mode == MODE_EDGE) ? ~edge_flag : released;

    // R8
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> irq_n);

endmodule

// File: tb/irqc_top_test.sv
module irqc_top_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic contact_press = 1'b0;
    logic contact_release = 1'b1;
    logic irq_ack = 1'b0;
    logic mode_wr = 1'b0;
    logic mode_edge = 1'b0;
    logic irq_n;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    logic m_rel;
    logic m_flag;
    logic m_edge_mode;

    irqc_top uut (
        .clk             (clk),
        .rst             (rst),
        .contact_press   (contact_press),
        .contact_release (contact_release),
        .irq_ack         (irq_ack),
        .mode_wr         (mode_wr),
        .mode_edge       (mode_edge),
        .irq_n           (irq_n)
    );

    always #10 clk = ~clk;   // 50 MHz

    function automatic logic model_sr(input logic s, input logic r, input logic q);
        if (s && !r) return 1'b0;
        if (!s && r) return 1'b1;
        return q;
    endfunction

    function automatic logic model_irq(input logic em, input logic rel, input logic fl);
        return em ? ~fl : rel;
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: irq_n=%b expected %b", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        contact_press = 1'b0;
        contact_release = 1'b1;
        irq_ack = 1'b0;
        mode_wr = 1'b0;
        step(3);
        rst = 1'b0;
        m_rel = 1'b1;
        m_flag = 1'b0;
        m_edge_mode = 1'b0;
    endtask

    // Write issued so that it is sampled on cycle n after reset
    task automatic write_mode(input int n, input logic e);
        step(n);
        mode_wr = 1'b1;
        mode_edge = e;
        step(1);
        mode_wr = 1'b0;
    endtask

    task automatic set_contacts(input logic s, input logic r);
        logic prev;
        contact_press = s;
        contact_release = r;
        step(4);
        prev = m_rel;
        m_rel = model_sr(s, r, m_rel);
        if (m_edge_mode && prev && !m_rel) m_flag = 1'b1;
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1;
        step(1);
        irq_ack = 1'b0;
        if (m_edge_mode) m_flag = 1'b0;
    endtask

    task automatic random_run(input int steps, input string tag);
        for (int i = 0; i < steps; i++) begin
            logic [1:0] c;
            c = 2'($urandom_range(0, 3));
            set_contacts(c[1], c[0]);
            chk(tag, irq_n, model_irq(m_edge_mode, m_rel, m_flag));
            if ($urandom_range(0, 2) == 0) begin
                pulse_ack();
                chk(tag, irq_n, model_irq(m_edge_mode, m_rel, m_flag));
            end
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
            finish_run();
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5eed_1234);
        m_rel = 1'b1; m_flag = 1'b0; m_edge_mode = 1'b0;
        step(3);
        // R8: idle output while held in reset
        chk("R8 in reset", irq_n, 1'b1);
        rst = 1'b0;
        step(2);
        chk("R8 after reset", irq_n, 1'b1);

        // R1: latency of synchronizer plus latch, level mode
        do_reset();
        contact_press = 1'b1; contact_release = 1'b0;
        step(2);
        chk("R1 not before third edge", irq_n, 1'b1);
        step(1);
        chk("R1 at third edge", irq_n, 1'b0);
        m_rel = 1'b0;

        // R3: bounce (00) and both-closed (11) keep pressed
        set_contacts(1'b0, 1'b0);
        chk("R3 hold 00 pressed", irq_n, 1'b0);
        set_contacts(1'b1, 1'b1);
        chk("R3 hold 11 pressed", irq_n, 1'b0);
        // R4: ack ignored in level mode
        pulse_ack();
        step(2);
        chk("R4 ack ignored", irq_n, 1'b0);
        // R2: release
        set_contacts(1'b0, 1'b1);
        chk("R2 release", irq_n, 1'b1);
        set_contacts(1'b1, 1'b1);
        chk("R3 hold 11 released", irq_n, 1'b1);
        set_contacts(1'b1, 1'b0);
        chk("R2 press", irq_n, 1'b0);

        // R9: write on cycle 63 accepted, edge mode
        do_reset();
        write_mode(63, 1'b1);
        m_edge_mode = 1'b1;
        set_contacts(1'b1, 1'b0);
        chk("R5 press in edge mode", irq_n, 1'b0);
        set_contacts(1'b0, 1'b1);
        chk("R9 cycle 63 write took effect / R5 sticky", irq_n, 1'b0);
        pulse_ack();
        chk("R6 ack clears", irq_n, 1'b1);
        // R6: held button raises one request only
        set_contacts(1'b1, 1'b0);
        chk("R5 second press", irq_n, 1'b0);
        pulse_ack();
        chk("R6 ack while held", irq_n, 1'b1);
        step(6);
        chk("R6 no repeat while held", irq_n, 1'b1);
        set_contacts(1'b0, 1'b1);
        // R7: ack coincident with press edge (latch updates at third edge)
        contact_press = 1'b1; contact_release = 1'b0;
        step(2);
        irq_ack = 1'b1;
        step(1);
        irq_ack = 1'b0;
        m_rel = 1'b0;
        m_flag = 1'b1;
        chk("R7 press wins over ack", irq_n, 1'b0);
        step(3);
        chk("R7 request kept", irq_n, 1'b0);

        // R9: write on cycle 64 ignored
        do_reset();
        write_mode(64, 1'b1);
        set_contacts(1'b1, 1'b0);
        set_contacts(1'b0, 1'b1);
        chk("R9 cycle 64 write ignored", irq_n, 1'b1);

        // R9: write-once, second write ignored
        do_reset();
        write_mode(5, 1'b1);
        write_mode(5, 1'b0);
        m_edge_mode = 1'b1;
        set_contacts(1'b1, 1'b0);
        set_contacts(1'b0, 1'b1);
        chk("R9 second write ignored", irq_n, 1'b0);
        // R9: a level write locks too
        do_reset();
        write_mode(2, 1'b0);
        write_mode(2, 1'b1);
        set_contacts(1'b1, 1'b0);
        set_contacts(1'b0, 1'b1);
        chk("R9 level write locks", irq_n, 1'b1);

        // Random: level mode (R2 R3 R4)
        do_reset();
        random_run(300, "R4 random level");
        // Random: edge mode (R5 R6)
        do_reset();
        write_mode(0, 1'b1);
        m_edge_mode = 1'b1;
        random_run(300, "R5 random edge");

        if (seed == 0) step(1);
        finish_run();
    end
endmodule